// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is the host-side door into a bank of sixteen 8-bit configuration registers. A controller talks to it over a four-wire serial link: an active-low frame select, a serial clock, a data line into the block and a data line out of it. Each frame carries one command. That command either writes a byte into one register or names a register to read. The current contents of the whole bank are always present on a wide parallel output, which feeds the datapath it configures.

The serial pins are oversampled by the block's own system clock through synchronizers, so the serial clock must run well below the system clock. A write takes effect when the frame select returns high. A read works as a pipeline: during any frame, the block shifts out the register that the previous command named. One control register holds two bits that steer the port itself. One gates the serial output. The other freezes the four offset registers against serial writes while an automatic calibration owns them.

Top module: `cfg_serial_port`

## Requirements
- R1: After reset the bank holds: addresses 0x0-0x3 = 0x00, 0x4-0x7 = 0x20, 0x8 = 0x10, 0x9-0xB = 0x00, 0xC = 0x4E, 0xD = 0x00, 0xE = 0xAA, 0xF = 0x5A.
- R2: Serial input is taken on each rising edge of the serial clock while frame select is low. A command is 13 bits, sent first to last as: the direction bit (0 = write, 1 = read), the 4-bit address MSB first, then 8 data bits MSB first.
- R3: When frame select rises after a write command, the data byte is stored in the addressed register. No register changes at any other time.
- R4: A read command changes no register. Its data bits are ignored.
- R5: A frame longer than 13 bits is decoded from its last 13 bits only. Earlier bits are dropped.
- R6: A frame shorter than 13 bits commits nothing and leaves the armed read address unchanged.
- R7: When frame select falls, the register at the address named by the last complete command (read or write; address 0x0 after reset) is presented MSB first on the serial output. The output advances one bit on each falling edge of the serial clock.
- R8: The serial output is driven with data only while bit 6 of register 0xC is 1 and frame select is low. Otherwise it is held at 0.
- R9: While bit 3 of register 0xC is 1, writes to addresses 0x4-0x7 are dropped. Writes to all other addresses still take effect.
- R10: The parallel output carries register a on bits [8a+7:8a]. A committed write shows there within four system clocks of frame select rising.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Active-low serial frame select |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data into the block |
| sdo | output | 1 | Serial data out of the block |
| cfg_o | output | 128 | All sixteen registers, register a on bits [8a+7:8a] |

## Verification
Each serial pin passes two synchronizer flops, and one more register detects the edge. A register write therefore reaches the parallel output four system clocks after frame select rises. A new read byte is present on the serial output three clocks after frame select falls, and every later bit is present three clocks after a serial-clock fall. The bench holds each serial half-period for six system clocks and samples the serial output just before it raises the serial clock. It waits twelve clocks after closing a frame before it inspects the parallel output, so every result is settled when it is read.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
    localparam int REG_W      = 8;
    localparam int N_REGS     = 16;
    localparam int ADDR_W     = $clog2(N_REGS);
    localparam int FRAME_BITS = 1 + ADDR_W + REG_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);

    // control register and the bit positions the port itself decodes
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(12);
    localparam int OE_BIT   = 6;
    localparam int LOCK_BIT = 3;
    localparam int OFFS_LO  = 4;
    localparam int OFFS_HI  = 7;

    typedef logic [REG_W-1:0]  byte_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [N_REGS-1:0][REG_W-1:0] bank_t;

    function automatic byte_t reset_value(input int a);
        byte_t v;
        case (a)
            4, 5, 6, 7: v = 8'h20;
            8:          v = 8'h10;
            12:         v = 8'h4E;
            14:         v = 8'hAA;
            15:         v = 8'h5A;
            default:    v = 8'h00;
        endcase
        return v;
    endfunction

    function automatic bank_t reset_bank();
        bank_t b;
        for (int i = 0; i < N_REGS; i++) b[i] = reset_value(i);
        return b;
    endfunction

    function automatic logic is_offset(input addr_t a);
        return (int'(a) >= OFFS_LO) && (int'(a) <= OFFS_HI);
    endfunction
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] st_d, st_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb st_d = d;
        end else begin : g_chain
            always_comb st_d = {st_q[STAGES-2:0], d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= {STAGES{RST_VAL}};
        else        st_q <= st_d;
    end

    assign q = st_q[STAGES-1];
endmodule

// File: rtl/cfg_frame.sv
module cfg_frame
    import cfgport_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ce_n_i,
    input  logic  sclk_i,
    input  logic  sdi_i,
    input  byte_t rd_byte_i,
    output addr_t arm_addr_o,
    output logic  tx_bit_o,
    output logic  wr_en_o,
    output addr_t wr_addr_o,
    output byte_t wr_data_o
);
    typedef struct packed {
        logic [FRAME_BITS-1:0] sh;
        logic [CNT_W-1:0]      cnt;
        byte_t                 tx;
        addr_t                 arm;
        logic                  wr_en;
        addr_t                 wr_addr;
        byte_t                 wr_data;
        logic                  ce_p;
        logic                  sclk_p;
    } frame_st_t;

    localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_BITS);

    frame_st_t st_d, st_q;
    logic ce_fall, ce_rise, sc_rise, sc_fall;

    always_comb begin
        ce_fall = st_q.ce_p & ~ce_n_i;
        ce_rise = ~st_q.ce_p & ce_n_i;
        sc_rise = ~st_q.sclk_p & sclk_i;
        sc_fall = st_q.sclk_p & ~sclk_i;

        st_d        = st_q;
        st_d.wr_en  = 1'b0;
        st_d.ce_p   = ce_n_i;
        st_d.sclk_p = sclk_i;

        if (ce_fall) begin
            st_d.cnt = '0;
            st_d.tx  = rd_byte_i;
        end else if (ce_rise) begin
            if (st_q.cnt == FULL) begin
                st_d.arm = st_q.sh[FRAME_BITS-2 -: ADDR_W];
                if (!st_q.sh[FRAME_BITS-1]) begin
                    st_d.wr_en   = 1'b1;
                    st_d.wr_addr = st_q.sh[FRAME_BITS-2 -: ADDR_W];
                    st_d.wr_data = st_q.sh[REG_W-1:0];
                end
            end
        end else if (!ce_n_i) begin
            if (sc_rise) begin
                st_d.sh = {st_q.sh[FRAME_BITS-2:0], sdi_i};
                if (st_q.cnt != FULL) st_d.cnt = st_q.cnt + 1'b1;
            end
            if (sc_fall) st_d.tx = {st_q.tx[REG_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.ce_p   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign arm_addr_o = st_q.arm;
    assign tx_bit_o   = st_q.tx[REG_W-1];
    assign wr_en_o    = st_q.wr_en;
    assign wr_addr_o  = st_q.wr_addr;
    assign wr_data_o  = st_q.wr_data;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL); // R5
    AST_WR_FULL_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wr_en |-> ($past(st_q.cnt) == FULL) && !$past(st_q.sh[FRAME_BITS-1])); // R6
    AST_WR_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wr_en |=> !st_q.wr_en); // R3
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
    import cfgport_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en_i,
    input  addr_t wr_addr_i,
    input  byte_t wr_data_i,
    output bank_t bank_o
);
    typedef struct packed {
        bank_t r;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic     locked;

    always_comb begin
        locked = st_q.r[CTRL_ADDR][LOCK_BIT];
        st_d   = st_q;
        if (wr_en_i && !(locked && is_offset(wr_addr_i)))
            st_d.r[wr_addr_i] = wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.r <= reset_bank();
        else        st_q   <= st_d;
    end

    assign bank_o = st_q.r;

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(st_q.r)); // R3
    AST_OFFSET_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && st_q.r[CTRL_ADDR][LOCK_BIT] && is_offset(wr_addr_i)) |=> $stable(st_q.r)); // R9
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
    import cfgport_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ce_n,
    input  logic                    sclk,
    input  logic                    sdi,
    output logic                    sdo,
    output logic [N_REGS*REG_W-1:0] cfg_o
);
    logic  ce_s, sclk_s, sdi_s;
    addr_t arm_addr;
    logic  tx_bit;
    logic  wr_en;
    addr_t wr_addr;
    byte_t wr_data;
    bank_t bank;
    byte_t rd_byte;
    logic  out_en;

    cfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ce (
        .clk(clk), .rst_n(rst_n), .d(ce_n), .q(ce_s));
    cfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
        .clk(clk), .rst_n(rst_n), .d(sclk), .q(sclk_s));
    cfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdi (
        .clk(clk), .rst_n(rst_n), .d(sdi), .q(sdi_s));

    cfg_frame u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_n_i     (ce_s),
        .sclk_i     (sclk_s),
        .sdi_i      (sdi_s),
        .rd_byte_i  (rd_byte),
        .arm_addr_o (arm_addr),
        .tx_bit_o   (tx_bit),
        .wr_en_o    (wr_en),
        .wr_addr_o  (wr_addr),
        .wr_data_o  (wr_data)
    );

    cfg_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .bank_o    (bank)
    );

    always_comb begin
        rd_byte = bank[arm_addr];
        out_en  = bank[CTRL_ADDR][OE_BIT];
        sdo     = out_en & ~ce_s & tx_bit;
    end

    assign cfg_o = bank;
endmodule

// File: tb/tb_cfg_serial_port.sv
module tb_cfg_serial_port;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 6;
    localparam int WATCHDOG = 200000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic sdo;
    logic [127:0] cfg_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    cfg_serial_port dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .sclk(sclk),
        .sdi(sdi), .sdo(sdo), .cfg_o(cfg_o));

    always #(CLK_PERIOD/2) clk = ~clk;

    // {dir, addr, data, expected register value afterwards}
    localparam logic [20:0] VEC [0:6] = '{
        {1'b0, 4'h0, 8'h3C, 8'h3C},
        {1'b0, 4'h9, 8'hA5, 8'hA5},
        {1'b0, 4'h5, 8'h77, 8'h20},
        {1'b0, 4'hC, 8'h40, 8'h40},
        {1'b0, 4'h5, 8'h77, 8'h77},
        {1'b0, 4'hF, 8'h81, 8'h81},
        {1'b1, 4'hE, 8'hFF, 8'hAA}
    };

    function automatic logic [7:0] dflt(input int a);
        if (a >= 4 && a <= 7) return 8'h20;
        if (a == 8)  return 8'h10;
        if (a == 12) return 8'h4E;
        if (a == 14) return 8'hAA;
        if (a == 15) return 8'h5A;
        return 8'h00;
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", what, act, exp);
        end
    endtask

    task automatic frame(input int nbits, input logic [31:0] bits, output logic [7:0] rd);
        rd = 8'h00;
        ce_n = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < nbits; i++) begin
            sdi = bits[nbits-1-i];
            wait_clk(HALF);
            if (i < 8) rd[7-i] = sdo;
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
        wait_clk(HALF);
        ce_n = 1'b1;
        wait_clk(2*HALF);
    endtask

    function automatic logic [31:0] cmd(input logic dir, input logic [3:0] a, input logic [7:0] d);
        return {19'd0, dir, a, d};
    endfunction

    function automatic logic [7:0] reg_of(input int a);
        return cfg_o[8*a +: 8];
    endfunction

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        logic [7:0] scratch;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(3);

        // R1 R10: reset contents on the parallel output
        for (int a = 0; a < 16; a++)
            check8(reg_of(a), dflt(a), $sformatf("R1 R10 reset addr %0d", a));
        // R8: idle output low while frame select high
        check8({7'd0, sdo}, 8'h00, "R8 idle sdo");

        // table walk: R2 R3 R4 R9 R7
        for (int k = 0; k < 7; k++) begin
            logic [20:0] v;
            string tag;
            v = VEC[k];
            tag = (k == 2) ? "R9" : (k == 6) ? "R4" : "R2 R3";
            frame(13, cmd(v[20], v[19:16], v[15:8]), scratch);
            check8(reg_of(int'(v[19:16])), v[7:0], $sformatf("%s vector %0d register", tag, k));
            frame(13, cmd(1'b1, 4'h0, 8'h00), rd);
            check8(rd, v[7:0], $sformatf("R7 vector %0d readback", k));
        end

        // R5: 20-bit frame, leading 7 bits discarded
        frame(20, {12'd0, 7'b1011011, 1'b0, 4'h2, 8'h5B}, scratch);
        check8(reg_of(2), 8'h5B, "R5 long frame write");
        frame(13, cmd(1'b1, 4'h0, 8'h00), rd);
        check8(rd, 8'h5B, "R5 long frame armed address");

        // R6: short frame ignored, armed address kept
        frame(13, cmd(1'b0, 4'h9, 8'h11), scratch);
        frame(12, {20'd0, 1'b0, 4'h3, 7'h77}, scratch);
        check8(reg_of(3), 8'h00, "R6 short frame no write");
        frame(13, cmd(1'b1, 4'h0, 8'h00), rd);
        check8(rd, 8'h11, "R6 short frame armed address unchanged");

        // R8: output disabled
        frame(13, cmd(1'b0, 4'hC, 8'h00), scratch);
        frame(13, cmd(1'b1, 4'hF, 8'h00), scratch);
        frame(13, cmd(1'b1, 4'h0, 8'h00), rd);
        check8(rd, 8'h00, "R8 output disabled");
        frame(13, cmd(1'b0, 4'hC, 8'h48), scratch);
        frame(13, cmd(1'b1, 4'hF, 8'h00), scratch);
        frame(13, cmd(1'b1, 4'h0, 8'h00), rd);
        check8(rd, 8'h81, "R7 R8 output re-enabled");

        // R9: lock on again; offset dropped, neighbour accepted
        frame(13, cmd(1'b0, 4'h6, 8'h99), scratch);
        check8(reg_of(6), 8'h20, "R9 locked offset write dropped");
        frame(13, cmd(1'b0, 4'h8, 8'h33), scratch);
        check8(reg_of(8), 8'h33, "R9 non-offset write while locked");
        frame(13, cmd(1'b0, 4'h3, 8'h44), scratch);
        check8(reg_of(3), 8'h44, "R9 address 3 below offset range");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule